// File: doc/BRIEF.md
# Packed Saturating Rounding Multiply-High Unit

This block is a pipelined, lane-parallel arithmetic unit. It takes two packed 128-bit operands and a 2-bit lane-size code that splits each operand into equal signed lanes of 8, 16, 32 or 64 bits. For each pair of matching lanes it forms the full-precision product, doubles it, adds half of one output unit as a rounding bias, and keeps the upper half of the sum. That upper half is then clamped to the lane's signed range, and the lane's saturation flag records whether clamping happened.

Every lane of the result is written on every operation. No lane is masked off. The lane-size code is captured together with the operands and travels down the pipeline with them, so consecutive operations can use different lane widths without stalling. A result leaves the unit exactly three cycles after its operands were accepted. The only input pair that saturates is the most negative lane value multiplied by itself.

Top module: `rmh_top`

## Requirements
- R1: The size code `in_size` selects the lane width as 8 shifted left by the code (0→8, 1→16, 2→32, 3→64 bits). The operand is split into 128/width lanes, and lane i occupies bits [i*width +: width].
- R2: Each lane result equals floor((2·a·b + 2^(N−1)) / 2^N), clamped to [−2^(N−1), 2^(N−1)−1]. Here a and b are the lane inputs read as two's-complement and N is the lane width.
- R3: The flag bit `out_sat[i]` is 1 exactly when lane i was clamped. This happens only when both lane inputs equal −2^(N−1), and the lane result is then 2^(N−1)−1. Flag bits at index 128/N and above are 0.
- R4: `out_valid` is high in cycle k+3 exactly when `in_valid` was high in cycle k, and is low otherwise.
- R5: The size code travels with its operands, so back-to-back operations with differing size codes each produce results for their own lane width.
- R6: Every lane of `out_data` is written on every valid operation. No lane keeps an old value.
- R7: While synchronous active-high reset `rst` is applied, `out_valid`, `out_data` and `out_sat` are 0 after the next clock edge.
- R8: A doubled product whose low half is exactly 2^(N−1) rounds toward positive infinity. A doubled product one step below that boundary rounds down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and size code are valid this cycle |
| in_size | input | 2 | Lane-size code (0:8, 1:16, 2:32, 3:64 bits) |
| in_a | input | 128 | First packed signed operand |
| in_b | input | 128 | Second packed signed operand |
| out_valid | output | 1 | Result valid, three cycles after `in_valid` |
| out_data | output | 128 | Packed rounded, saturated high halves |
| out_sat | output | 16 | Per-lane saturation flags, lane i at bit i |

## Verification
The size code is a piece of pipeline state. If it is lost or delayed, the next result shows up in the wrong lane width, with lane boundaries shifted and flags set at wrong indices. The mixed-size sequences expose this on the first operation whose code differs from its predecessor.

A faulty product or rounding register in any lane shows up as a wrong value in that lane three cycles after the operands. The corner and tie patterns turn an off-by-one rounding error or a missing clamp into a visible mismatch in that same cycle. A broken valid pipeline shows up as `out_valid` out of step with the reference on the first idle gap or burst.

// File: rtl/rmh_pkg.sv
package rmh_pkg;

    // Total packed vector width and derived lane limits
    localparam int VEC_W     = 128;
    localparam int MIN_LW    = 8;
    localparam int MAX_LANES = VEC_W / MIN_LW;
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } lane_sz_e;

    // Operands as captured by the first pipeline stage
    typedef struct packed {
        logic             valid;
        lane_sz_e         sz;
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
    } op_s;

    // Control that follows the operands through the multiply stage
    typedef struct packed {
        logic     valid;
        lane_sz_e sz;
    } ctl_s;

    function automatic int lane_bits(input lane_sz_e sz);
        return MIN_LW << sz;
    endfunction

    function automatic int lane_count(input lane_sz_e sz);
        return MAX_LANES >> sz;
    endfunction

endpackage

// File: rtl/rmh_lane.sv
// One signed lane: registered doubled product, then rounding and clamping.
module rmh_lane #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] a_i,
    input  logic [LW-1:0] b_i,
    output logic [LW-1:0] res_o,
    output logic          sat_o
);
    localparam int PW = 2 * LW + 2;
    localparam logic signed [PW-1:0] HALF   = $signed(PW'(1) << (LW - 1));
    localparam logic signed [PW-1:0] MAXV   = $signed((PW'(1) << (LW - 1)) - PW'(1));
    localparam logic signed [PW-1:0] MINV   = -MAXV - $signed(PW'(1));
    localparam logic signed [PW-1:0] CORNER = $signed(PW'(1) << (2 * LW - 1));

    logic signed [PW-1:0] ax, bx;
    logic signed [PW-1:0] dbl_q;
    logic signed [PW-1:0] rnd, shr;

    assign ax = PW'($signed(a_i));
    assign bx = PW'($signed(b_i));

    always_ff @(posedge clk) begin
        if (rst) dbl_q <= '0;
        else     dbl_q <= (ax * bx) <<< 1;
    end

    always_comb begin
        rnd = dbl_q + HALF;
        shr = rnd >>> LW;
        if (shr > MAXV) begin
            res_o = MAXV[LW-1:0];
            sat_o = 1'b1;
        end else if (shr < MINV) begin
            res_o = MINV[LW-1:0];
            sat_o = 1'b1;
        end else begin
            res_o = shr[LW-1:0];
            sat_o = 1'b0;
        end
    end

    // R3: clamping only ever follows the most-negative squared corner
    assert_sat_corner_R3: assert property (@(posedge clk) disable iff (rst)
        sat_o |-> (dbl_q == CORNER));

    // R3: a clamped lane always carries the positive limit
    assert_sat_value_R3: assert property (@(posedge clk) disable iff (rst)
        sat_o |-> (res_o == MAXV[LW-1:0]));

endmodule

// File: rtl/rmh_bank.sv
// All lanes of one fixed width across the packed vector.
module rmh_bank #(
    parameter int VW = 128,
    parameter int LW = 8,
    localparam int NL = VW / LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] a_i,
    input  logic [VW-1:0] b_i,
    output logic [VW-1:0] res_o,
    output logic [NL-1:0] sat_o
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        rmh_lane #(.LW(LW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .a_i  (a_i[g*LW +: LW]),
            .b_i  (b_i[g*LW +: LW]),
            .res_o(res_o[g*LW +: LW]),
            .sat_o(sat_o[g])
        );
    end

endmodule

// File: rtl/rmh_top.sv
// Three-stage packed saturating rounding multiply-high unit.
module rmh_top
    import rmh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_size,
    input  logic [VEC_W-1:0]     in_a,
    input  logic [VEC_W-1:0]     in_b,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     out_data,
    output logic [MAX_LANES-1:0] out_sat
);
    op_s                  s1_q;
    ctl_s                 s2_q;
    lane_sz_e             out_sz_q;
    logic [VEC_W-1:0]     bank_res [NUM_SIZES];
    logic [MAX_LANES-1:0] bank_sat [NUM_SIZES];
    logic [VEC_W-1:0]     sel_res;
    logic [MAX_LANES-1:0] sel_sat;

    // Stage 1: capture operands with their size code
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            s1_q.sz    <= lane_sz_e'(in_size);
            s1_q.a     <= in_a;
            s1_q.b     <= in_b;
        end
    end

    // Stage 2: one bank per lane width, products registered inside lanes
    for (genvar w = 0; w < NUM_SIZES; w++) begin : g_bank
        localparam int BLW = MIN_LW << w;
        localparam int BNL = VEC_W / BLW;
        logic [BNL-1:0] sat_w;

        rmh_bank #(.VW(VEC_W), .LW(BLW)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .a_i  (s1_q.a),
            .b_i  (s1_q.b),
            .res_o(bank_res[w]),
            .sat_o(sat_w)
        );
        assign bank_sat[w] = MAX_LANES'(sat_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid <= s1_q.valid;
            s2_q.sz    <= s1_q.sz;
        end
    end

    // Stage 3: pick the bank matching the carried size code
    always_comb begin
        sel_res = bank_res[s2_q.sz];
        sel_sat = bank_sat[s2_q.sz];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sat   <= '0;
            out_sz_q  <= SZ_B8;
        end else begin
            out_valid <= s2_q.valid;
            out_data  <= sel_res;
            out_sat   <= sel_sat;
            out_sz_q  <= s2_q.sz;
        end
    end

    // Cycles since reset release, saturating, so $past stays within them
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R4: fixed three-cycle latency of the valid flag
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R5: the size code arrives with its own result
    assert_size_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && out_valid) |-> (out_sz_q == lane_sz_e'($past(in_size, 3))));

    // R3: no flag above the lane count of the current width
    assert_flag_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_sat >> (MAX_LANES >> out_sz_q)) == '0));

    // R7: reset leaves the outputs quiet
    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && out_sat == '0));

endmodule

// File: tb/sim_rmh_top.sv
module sim_rmh_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_size = 2'd0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic [15:0]  out_sat;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    rmh_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_data(out_data), .out_sat(out_sat)
    );

    typedef struct {
        logic         v;
        logic [127:0] d;
        logic [15:0]  f;
        string        tag;
    } exp_t;

    exp_t q[$];

    // Wide-precision reference of the whole packed operation
    function automatic void ref_vec(input logic [1:0] sz, input logic [127:0] a,
                                    input logic [127:0] b, output logic [127:0] r,
                                    output logic [15:0] f);
        int n = 8 << sz;
        int nl = 128 / n;
        logic [63:0] mask = (n == 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
        r = '0;
        f = '0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] ua, ub;
            logic signed [131:0] x, y, p, s, mx, mn;
            ua = 64'(a >> (l * n)) & mask;
            ub = 64'(b >> (l * n)) & mask;
            x = $signed({68'd0, ua});
            y = $signed({68'd0, ub});
            if (ua[n-1]) x = x - (132'sd1 <<< n);
            if (ub[n-1]) y = y - (132'sd1 <<< n);
            p = 2 * x * y + (132'sd1 <<< (n - 1));
            s = p >>> n;
            mx = (132'sd1 <<< (n - 1)) - 132'sd1;
            mn = -(132'sd1 <<< (n - 1));
            if (s > mx) begin s = mx; f[l] = 1'b1; end
            else if (s < mn) begin s = mn; f[l] = 1'b1; end
            r = r | (128'(s[63:0] & mask) << (l * n));
        end
    endfunction

    // Model pipeline: one entry per clock edge
    always @(posedge clk) begin
        exp_t e;
        e.tag = cur_tag;
        if (rst || !in_valid) begin
            e.v = 1'b0; e.d = '0; e.f = '0;
        end else begin
            e.v = 1'b1;
            ref_vec(in_size, in_a, in_b, e.d, e.f);
        end
        q.push_back(e);
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (!done && rst && q.size() > 0) begin
            total++;
            if (out_valid !== 1'b0 || out_data !== '0 || out_sat !== '0) begin
                bad++;
                $display("FAIL R7 reset: valid=%b data=%h sat=%h expected 0/0/0",
                         out_valid, out_data, out_sat);
            end
        end else if (!done && !rst && q.size() >= 3) begin
            exp_t e;
            e = q[q.size() - 3];
            total++;
            if (out_valid !== e.v) begin
                bad++;
                $display("FAIL R4 valid: got %b expected %b", out_valid, e.v);
            end
            if (e.v) begin
                total++;
                if (out_data !== e.d) begin
                    bad++;
                    $display("FAIL %s R2 R6 data: got %h expected %h", e.tag, out_data, e.d);
                end
                total++;
                if (out_sat !== e.f) begin
                    bad++;
                    $display("FAIL %s R3 flags: got %h expected %h", e.tag, out_sat, e.f);
                end
            end
        end
        while (q.size() > 3) void'(q.pop_front());
    end

    // Lane pattern: kinds cover corner, limits and rounding boundaries
    function automatic logic [63:0] pat(input int kind, input int n, input bit second);
        logic signed [64:0] mn = -(65'sd1 <<< (n - 1));
        logic signed [64:0] mx = (65'sd1 <<< (n - 1)) - 65'sd1;
        logic signed [64:0] qt = 65'sd1 <<< (n - 2);
        logic signed [64:0] v;
        case (kind)
            0: v = mn;                                      // R3 corner
            1: v = second ? mx : mn;
            2: v = second ? qt : 65'sd1;                    // R8 positive tie
            3: v = second ? qt - 65'sd1 : 65'sd1;           // R8 just below
            4: v = second ? qt : -65'sd1;                   // R8 negative tie
            5: v = second ? qt + 65'sd1 : -65'sd1;          // R8 just beyond
            6: v = second ? mn + 65'sd1 : mn;               // R3 near corner
            default: v = mx;
        endcase
        return v[63:0];
    endfunction

    task automatic issue(input logic [1:0] sz, input logic [127:0] a, input logic [127:0] b);
        in_valid = 1'b1;
        in_size  = sz;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pattern_op(input logic [1:0] sz, input int off);
        int n = 8 << sz;
        int nl = 128 / n;
        logic [127:0] a = '0, b = '0;
        for (int l = 0; l < nl; l++) begin
            a = a | (128'(pat((l + off) % 8, n, 1'b0)) & ((n == 64) ? 128'({64{1'b1}}) : ((128'd1 << n) - 128'd1))) << (l * n);
            b = b | (128'(pat((l + off) % 8, n, 1'b1)) & ((n == 64) ? 128'({64{1'b1}}) : ((128'd1 << n) - 128'd1))) << (l * n);
        end
        issue(sz, a, b);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 and R8: every size, every pattern at every lane position
        cur_tag = "R1";
        for (int s = 0; s < 4; s++) begin
            for (int off = 0; off < 8; off++) begin
                if (off == 4) cur_tag = "R8";
                pattern_op(2'(s), off);
            end
            cur_tag = "R1";
            repeat (2) @(negedge clk);
        end

        // R3: all-lane most-negative squares in every size
        cur_tag = "R3";
        for (int s = 0; s < 4; s++) begin
            logic [127:0] m = '0;
            int n = 8 << s;
            for (int l = 0; l < 128 / n; l++) m[l * n + n - 1] = 1'b1;
            issue(2'(s), m, m);
        end

        // R5: back-to-back random sizes and values with idle gaps (R4)
        cur_tag = "R5";
        for (int i = 0; i < 400; i++) begin
            logic [127:0] a = rnd128();
            logic [127:0] b = ($urandom_range(0, 3) == 0) ? a : rnd128();
            issue(2'($urandom_range(0, 3)), a, b);
            if ($urandom_range(0, 4) == 0) @(negedge clk);
        end

        repeat (6) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule